// File: doc/BRIEF.md
# SPI Packet and Loop Sequencer

This block sequences the byte stream of an SPI master transfer. A transfer is a number of equal packets; the packet length and the packet count are both programmed as value-minus-one, so a transfer carries (length+1)·(count+1) bytes. The sequencer counts bytes inside the current packet and packets inside the transfer, takes transmit bytes from a valid/ready stream, serialises them on a fixed mode-0 serial clock, and hands received bytes to a second valid/ready stream.

A one-cycle activate pulse starts a transfer from idle. Between packets the chip select is either released for a programmable idle interval or, in gapless mode, held so that the packets run as one continuous burst. When pause is enabled the sequencer stops at the end of the transfer with chip select still asserted and waits for a resume pulse, which runs a further transfer of the programmed shape under the same chip select. A synchronous software reset aborts everything. Transmit and receive bit order are chosen independently.

Top module: `spi_pkt_seq`

## Requirements
- R1: While rst_ni is low, status_o is 2'b00, cs_no_o is 1, sclk_o is 0, tx_ready_o is 0 and rx_valid_o is 0.
- R2: One transfer moves exactly (pkt_len_i+1)·(pkt_loop_i+1) bytes: that many transmit handshakes and that many receive bytes.
- R3: act_i starts a transfer only from idle; act_i while paused and resume_i while idle have no effect on status, chip select or the byte stream.
- R4: With nonidle_i low, chip select is asserted once per packet and is released between packets for exactly cs_idle_i+1 clock cycles.
- R5: With nonidle_i high, chip select is asserted once for the whole transfer and rises only when the transfer is done (or on software reset).
- R6: status_o[0] (done) goes to 1 when a transfer finishes to idle and stays 1 until the next accepted activate or a software reset; status_o[1] (paused) and status_o[0] are never both 1.
- R7: With pause_en_i high at the end of a transfer, the block reports status_o = 2'b10 with chip select held and no bytes moving; resume_i then runs another full transfer under the same chip select.
- R8: sw_rst_i returns the block to idle in the next cycle: status_o = 2'b00, chip select released, serial clock low, counters cleared.
- R9: With tx_msb_first_i = 1 bit 7 of each byte goes out first on mosi_o, with 0 bit 0 goes first.
- R10: With rx_msb_first_i = 1 the first received bit ends in rx_data_o[7], with 0 it ends in rx_data_o[0].
- R11: Each bit takes two clock cycles, serial clock low then high; mosi_o is stable over the bit and miso_i is sampled at the end of the high cycle; sclk_o is high only under an asserted chip select.
- R12: While rx_valid_o is high and rx_ready_i is low, rx_data_o holds and no new byte starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Start pulse, accepted in idle |
| resume_i | input | 1 | Continue pulse, accepted when paused |
| sw_rst_i | input | 1 | Synchronous abort to idle |
| pause_en_i | input | 1 | Stop in paused state at transfer end |
| nonidle_i | input | 1 | Gapless packets under one chip select |
| tx_msb_first_i | input | 1 | Transmit bit order |
| rx_msb_first_i | input | 1 | Receive bit order |
| pkt_len_i | input | LEN_W | Bytes per packet minus one |
| pkt_loop_i | input | LOOP_W | Packets per transfer minus one |
| cs_idle_i | input | IDLE_W | Chip select release between packets, cycles minus one |
| tx_data_i | input | DW | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmit byte taken |
| rx_data_o | output | DW | Received byte |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Received byte taken |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no_o | output | 1 | Chip select, active low |
| status_o | output | 2 | Bit 0 done, bit 1 paused |

## Verification
The bench builds the block with LEN_W = 16, IDLE_W = 8, DW = 8 and a narrow LOOP_W = 3, so the largest packet count of eight, and the wrap of the packet counter at its field maximum, is reached in a short run. A loopback from mosi_o to miso_i lets the receive side be predicted from the transmit stream under every pairing of bit orders, and an idle interval of 3 makes the four-cycle chip select release measurable between packets.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_SHIFT,
    ST_GAP,
    ST_PAUSE
  } seq_state_e;
endpackage

// File: rtl/spi_seq_cnt.sv
module spi_seq_cnt #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LOOP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [LOOP_W-1:0] pkt_loop_i,
  output logic              last_byte_o,
  output logic              last_pkt_o
);
  logic [LEN_W-1:0]  byte_q;
  logic [LOOP_W-1:0] pkt_q;

  assign last_byte_o = (byte_q == pkt_len_i);
  assign last_pkt_o  = (pkt_q == pkt_loop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      pkt_q  <= '0;
    end else if (clr_i) begin
      byte_q <= '0;
      pkt_q  <= '0;
    end else if (step_i) begin
      if (last_byte_o) begin
        byte_q <= '0;
        pkt_q  <= last_pkt_o ? '0 : pkt_q + 1'b1;
      end else begin
        byte_q <= byte_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [DW-1:0] tx_byte_i,
  input  logic          tx_msb_i,
  input  logic          rx_msb_i,
  input  logic          miso_i,
  input  logic          rx_ready_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          byte_done_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o
);
  localparam int unsigned CNT_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  logic          busy_q, ph_q, tx_msb_q, rx_msb_q, rx_valid_q;
  logic [CNT_W-1:0] bit_q;
  logic [DW-1:0] sh_q, rx_sh_q, rx_data_q, rx_nxt;

  always_comb
    rx_nxt = rx_msb_q ? {rx_sh_q[DW-2:0], miso_i} : {miso_i, rx_sh_q[DW-1:1]};

  assign mosi_o      = tx_msb_q ? sh_q[DW-1] : sh_q[0];
  assign sclk_o      = ph_q;
  assign byte_done_o = busy_q & ph_q & (bit_q == LAST_BIT);
  assign rx_data_o   = rx_data_q;
  assign rx_valid_o  = rx_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ph_q       <= 1'b0;
      tx_msb_q   <= 1'b1;
      rx_msb_q   <= 1'b1;
      rx_valid_q <= 1'b0;
      bit_q      <= '0;
      sh_q       <= '0;
      rx_sh_q    <= '0;
      rx_data_q  <= '0;
    end else if (clr_i) begin
      busy_q     <= 1'b0;
      ph_q       <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      if (rx_valid_q && rx_ready_i) rx_valid_q <= 1'b0;
      if (load_i) begin
        busy_q   <= 1'b1;
        ph_q     <= 1'b0;
        bit_q    <= '0;
        sh_q     <= tx_byte_i;
        tx_msb_q <= tx_msb_i;
        rx_msb_q <= rx_msb_i;
      end else if (busy_q) begin
        ph_q <= ~ph_q;
        if (ph_q) begin
          rx_sh_q <= rx_nxt;
          sh_q    <= tx_msb_q ? {sh_q[DW-2:0], 1'b0} : {1'b0, sh_q[DW-1:1]};
          bit_q   <= bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            busy_q     <= 1'b0;
            rx_data_q  <= rx_nxt;
            rx_valid_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_pkt_seq.sv
module spi_pkt_seq
  import spi_seq_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LOOP_W = 8,
  parameter int unsigned IDLE_W = 8,
  parameter int unsigned DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              resume_i,
  input  logic              sw_rst_i,
  input  logic              pause_en_i,
  input  logic              nonidle_i,
  input  logic              tx_msb_first_i,
  input  logic              rx_msb_first_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [LOOP_W-1:0] pkt_loop_i,
  input  logic [IDLE_W-1:0] cs_idle_i,
  input  logic [DW-1:0]     tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DW-1:0]     rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no_o,
  output logic [1:0]        status_o
);
  seq_state_e        state_q;
  logic              done_q;
  logic [IDLE_W-1:0] gap_q;
  logic              last_byte, last_pkt, byte_done, load, cnt_clr;

  assign tx_ready_o = (state_q == ST_RUN) && (!rx_valid_o || rx_ready_i);
  assign load       = tx_valid_i && tx_ready_o;
  assign cnt_clr    = sw_rst_i || ((state_q == ST_IDLE) && act_i)
                   || ((state_q == ST_PAUSE) && resume_i);
  assign cs_no_o    = !((state_q == ST_RUN) || (state_q == ST_SHIFT)
                     || (state_q == ST_PAUSE));
  assign status_o   = {state_q == ST_PAUSE, done_q};

  spi_seq_cnt #(.LEN_W(LEN_W), .LOOP_W(LOOP_W)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (cnt_clr),
    .step_i      (byte_done),
    .pkt_len_i   (pkt_len_i),
    .pkt_loop_i  (pkt_loop_i),
    .last_byte_o (last_byte),
    .last_pkt_o  (last_pkt)
  );

  spi_seq_shift #(.DW(DW)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (sw_rst_i),
    .load_i      (load),
    .tx_byte_i   (tx_data_i),
    .tx_msb_i    (tx_msb_first_i),
    .rx_msb_i    (rx_msb_first_i),
    .miso_i      (miso_i),
    .rx_ready_i  (rx_ready_i),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .byte_done_o (byte_done),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      gap_q   <= '0;
    end else if (sw_rst_i) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (act_i) begin
          state_q <= ST_RUN;
          done_q  <= 1'b0;
        end
        ST_RUN: if (load) state_q <= ST_SHIFT;
        ST_SHIFT: if (byte_done) begin
          if (!last_byte) state_q <= ST_RUN;
          else if (!last_pkt) begin
            // packet boundary: release CS unless running gapless
            if (nonidle_i) state_q <= ST_RUN;
            else begin
              state_q <= ST_GAP;
              gap_q   <= cs_idle_i;
            end
          end else if (pause_en_i) state_q <= ST_PAUSE;
          else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_GAP: if (gap_q == '0) state_q <= ST_RUN;
                else gap_q <= gap_q - 1'b1;
        ST_PAUSE: if (resume_i) state_q <= ST_RUN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_pkt_seq_chk.sv
module spi_pkt_seq_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          act_i,
  input logic          sw_rst_i,
  input logic          nonidle_i,
  input logic          rx_ready_i,
  input logic [1:0]    status_o,
  input logic          cs_no_o,
  input logic          sclk_o,
  input logic          rx_valid_o,
  input logic [DW-1:0] rx_data_o
);
  // R6
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[0] && status_o[1]));

  // R6
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] && !act_i && !sw_rst_i |=> status_o[0]);

  // R7
  pause_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] |-> !cs_no_o);

  // R11
  sclk_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no_o);

  // R11
  sclk_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |=> !sclk_o);

  // R8
  swrst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (status_o == 2'b00) && cs_no_o && !sclk_o);

  // R12
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i && !sw_rst_i |=> rx_valid_o && $stable(rx_data_o));

  // R5
  nonidle_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nonidle_i && $rose(cs_no_o) && !$past(sw_rst_i) |-> status_o[0]);
endmodule

bind spi_pkt_seq spi_pkt_seq_chk #(.DW(DW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .act_i      (act_i),
  .sw_rst_i   (sw_rst_i),
  .nonidle_i  (nonidle_i),
  .rx_ready_i (rx_ready_i),
  .status_o   (status_o),
  .cs_no_o    (cs_no_o),
  .sclk_o     (sclk_o),
  .rx_valid_o (rx_valid_o),
  .rx_data_o  (rx_data_o)
);

// File: tb/test_spi_pkt_seq.sv
`timescale 1ns/1ps
module test_spi_pkt_seq;
  localparam int LEN_W = 16, LOOP_W = 3, IDLE_W = 8, DW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic act_i = 0, resume_i = 0, sw_rst_i = 0, pause_en_i = 0, nonidle_i = 0;
  logic tx_msb_first_i = 1, rx_msb_first_i = 1;
  logic [LEN_W-1:0]  pkt_len_i = '0;
  logic [LOOP_W-1:0] pkt_loop_i = '0;
  logic [IDLE_W-1:0] cs_idle_i = '0;
  logic [DW-1:0] tx_data_i, rx_data_o;
  logic tx_valid_i = 1'b1, tx_ready_o, rx_valid_o, rx_ready_i = 1'b1;
  logic sclk_o, mosi_o, miso_i, cs_no_o;
  logic [1:0] status_o;

  always #4 clk_i = ~clk_i;

  spi_pkt_seq #(.LEN_W(LEN_W), .LOOP_W(LOOP_W), .IDLE_W(IDLE_W), .DW(DW)) i_spi_pkt_seq (.*);

  assign miso_i = mosi_o;

  function automatic logic [7:0] tx_pat(input int i);
    return 8'((i * 29 + 90) ^ (i >> 3));
  endfunction
  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int k = 0; k < 8; k++) rev8[k] = b[7-k];
  endfunction

  int tx_n = 0;
  assign tx_data_i = tx_pat(tx_n);
  always @(posedge clk_i) if (tx_valid_i && tx_ready_o) tx_n <= tx_n + 1;

  // monitor
  logic [7:0] rx_mem [0:255];
  logic       mosi_bits [0:2047];
  int rx_n = 0, mosi_n = 0, cs_asserts = 0, gap_sum = 0, gap_cnt = 0, gap_run = 0;
  logic prev_sclk = 0, prev_cs = 1, gap_open = 0;
  always @(negedge clk_i) begin
    if (sclk_o && !prev_sclk) begin mosi_bits[mosi_n & 2047] = mosi_o; mosi_n++; end
    if (cs_no_o && !prev_cs) begin gap_open = !status_o[0]; gap_run = 1; end
    else if (cs_no_o) gap_run++;
    if (!cs_no_o && prev_cs) begin
      if (gap_open) begin gap_sum += gap_run; gap_cnt++; end
      cs_asserts++;
    end
    if (rx_valid_o && rx_ready_i) begin rx_mem[rx_n & 255] = rx_data_o; rx_n++; end
    prev_sclk = sclk_o;
    prev_cs = cs_no_o;
  end

  int vectors = 0, miscompares = 0;
  int tx_b, rx_b, mosi_b, cs_b, gsum_b, gcnt_b;

  task automatic chk(input string tag, input int actual, input int expected);
    vectors++;
    if (actual != expected) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic start_xfer(input int len, input int loop, input int idle, input bit ni,
                            input bit pe, input bit txm, input bit rxm);
    @(posedge clk_i); #1;
    pkt_len_i = LEN_W'(len); pkt_loop_i = LOOP_W'(loop); cs_idle_i = IDLE_W'(idle);
    nonidle_i = ni; pause_en_i = pe; tx_msb_first_i = txm; rx_msb_first_i = rxm;
    tx_b = tx_n; rx_b = rx_n; mosi_b = mosi_n; cs_b = cs_asserts; gsum_b = gap_sum; gcnt_b = gap_cnt;
    act_i = 1;
    @(posedge clk_i); #1;
    act_i = 0;
    chk("R6 done cleared by activate", status_o, 0);
  endtask

  task automatic pulse(input int which);
    @(posedge clk_i); #1;
    if (which == 0) act_i = 1; else if (which == 1) resume_i = 1; else sw_rst_i = 1;
    @(posedge clk_i); #1;
    act_i = 0; resume_i = 0; sw_rst_i = 0;
  endtask

  task automatic wait_status(input logic [1:0] mask, input string tag);
    int n = 0;
    while (n < 5000 && (status_o & mask) == 0) begin @(negedge clk_i); n++; end
    chk({tag, " reached end state"}, int'(n < 5000), 1);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic check_data(input int n, input bit txm, input bit rxm, input string tag);
    int errs = 0;
    for (int j = 0; j < n; j++) begin
      logic [7:0] b = tx_pat(tx_b + j);
      logic [7:0] e = (txm == rxm) ? b : rev8(b);
      if (rx_mem[(rx_b + j) & 255] !== e) errs++;
      for (int k = 0; k < 8; k++)
        if (mosi_bits[(mosi_b + 8*j + k) & 2047] !== (txm ? b[7-k] : b[k])) errs++;
    end
    chk({tag, " data/bit order mismatches"}, errs, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    chk("R1 status", status_o, 0);
    chk("R1 cs_n", cs_no_o, 1);
    chk("R1 sclk", sclk_o, 0);
    chk("R1 tx_ready", tx_ready_o, 0);
    chk("R1 rx_valid", rx_valid_o, 0);
    rst_ni = 1;
  endtask

  task automatic t_single;
    start_xfer(2, 0, 1, 0, 0, 1, 1);
    wait_status(2'b01, "R2");
    chk("R2 tx bytes", tx_n - tx_b, 3);
    chk("R2 rx bytes", rx_n - rx_b, 3);
    chk("R11 serial bits", mosi_n - mosi_b, 24);
    check_data(3, 1, 1, "R9 R10 R11");
    chk("R6 status done", status_o, 1);
    chk("R4 cs asserts single packet", cs_asserts - cs_b, 1);
    repeat (30) @(negedge clk_i);
    chk("R6 done held", status_o, 1);
  endtask

  task automatic t_gap;
    start_xfer(1, 2, 3, 0, 0, 1, 1);
    wait_status(2'b01, "R4");
    chk("R2 bytes 2x3", tx_n - tx_b, 6);
    chk("R4 cs asserts per packet", cs_asserts - cs_b, 3);
    chk("R4 gap count", gap_cnt - gcnt_b, 2);
    chk("R4 gap cycles", gap_sum - gsum_b, 8);
    check_data(6, 1, 1, "R4");
  endtask

  task automatic t_nonidle;
    start_xfer(1, 2, 3, 1, 0, 1, 1);
    wait_status(2'b01, "R5");
    chk("R5 bytes", rx_n - rx_b, 6);
    chk("R5 single cs assert", cs_asserts - cs_b, 1);
    chk("R5 no gaps", gap_cnt - gcnt_b, 0);
    check_data(6, 1, 1, "R5");
  endtask

  task automatic t_order;
    start_xfer(3, 0, 0, 0, 0, 0, 1);
    wait_status(2'b01, "R9");
    check_data(4, 0, 1, "R9 lsb-tx msb-rx");
    start_xfer(3, 0, 0, 0, 0, 1, 0);
    wait_status(2'b01, "R10");
    check_data(4, 1, 0, "R10 msb-tx lsb-rx");
    start_xfer(1, 0, 0, 0, 0, 0, 0);
    wait_status(2'b01, "R10");
    check_data(2, 0, 0, "R10 lsb both");
  endtask

  task automatic t_max_loop;
    start_xfer(0, 7, 0, 1, 0, 1, 1);
    wait_status(2'b01, "R2");
    chk("R2 max loop bytes", rx_n - rx_b, 8);
    check_data(8, 1, 1, "R2");
  endtask

  task automatic t_pause;
    int t0;
    start_xfer(1, 0, 0, 0, 1, 1, 1);
    wait_status(2'b10, "R7");
    chk("R7 paused status", status_o, 2);
    chk("R7 cs held", cs_no_o, 0);
    chk("R7 bytes before pause", tx_n - tx_b, 2);
    t0 = tx_n;
    pulse(0);
    repeat (10) @(negedge clk_i);
    chk("R3 act ignored while paused status", status_o, 2);
    chk("R3 act ignored while paused bytes", tx_n - t0, 0);
    @(posedge clk_i); #1 pause_en_i = 0;
    pulse(1);
    wait_status(2'b01, "R7");
    chk("R7 bytes after resume", rx_n - rx_b, 4);
    chk("R7 one cs assert", cs_asserts - cs_b, 1);
    check_data(4, 1, 1, "R7");
    chk("R7 done after resume", status_o, 1);
  endtask

  task automatic t_resume_idle;
    int t0 = tx_n;
    pulse(1);
    repeat (20) @(negedge clk_i);
    chk("R3 resume ignored in idle bytes", tx_n - t0, 0);
    chk("R3 resume ignored in idle status", status_o, 1);
    chk("R3 resume ignored in idle cs", cs_no_o, 1);
  endtask

  task automatic t_swrst;
    int n = 0, t0;
    start_xfer(15, 3, 2, 0, 0, 1, 1);
    while (n < 2000 && (tx_n - tx_b) < 5) begin @(negedge clk_i); n++; end
    pulse(2);
    @(negedge clk_i);
    chk("R8 status cleared", status_o, 0);
    chk("R8 cs released", cs_no_o, 1);
    chk("R8 sclk low", sclk_o, 0);
    t0 = tx_n;
    repeat (20) @(negedge clk_i);
    chk("R8 no traffic after reset", tx_n - t0, 0);
    start_xfer(1, 0, 0, 0, 0, 1, 1);
    wait_status(2'b01, "R8");
    chk("R8 fresh transfer bytes", rx_n - rx_b, 2);
    check_data(2, 1, 1, "R8");
  endtask

  task automatic t_backpressure;
    @(posedge clk_i); #1 rx_ready_i = 0;
    start_xfer(3, 0, 0, 0, 0, 1, 1);
    repeat (60) @(negedge clk_i);
    chk("R12 one byte started", tx_n - tx_b, 1);
    chk("R12 rx valid held", rx_valid_o, 1);
    chk("R12 rx data", rx_data_o, tx_pat(tx_b));
    @(posedge clk_i); #1 rx_ready_i = 1;
    wait_status(2'b01, "R12");
    chk("R12 bytes after release", rx_n - rx_b, 4);
    check_data(4, 1, 1, "R12");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_gap();
    t_nonidle();
    t_order();
    t_max_loop();
    t_pause();
    t_resume_idle();
    t_swrst();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule